// File: doc/BRIEF.md
# Code Block Segmenter

This block takes the CRC-terminated transport blocks of one transport channel for one transmission interval as a single serial bit stream. It joins them in arrival order and cuts the result into code blocks of one common size for the channel encoder. A configuration pulse supplies the total bit count and the coding type. The block then works out how many code blocks are needed and how long each one is. After that it streams the bits out with per-block first and last strobes, and it pads the front of the first block with zero filler bits so that every block has the same length.

The number of blocks C is the total length X divided by the coding limit Z, rounded up. The block size K is X divided by C, rounded up. Both quotients come from one shift-and-subtract divider that is used twice. While the divider runs, the block raises `busy` and accepts no input bits. Transport-block boundaries do not change the output: bits are joined purely in the order they arrive.

Top module: `tbcs_seg`

## Requirements
- R1: A `start` pulse with `cfg_len` = 0 produces no output beats; `done` is high in the cycle after `start` is taken, with `busy` low and `blk_count` = `blk_size` = 0.
- R2: When 0 < X <= Z, `blk_count` = 1 and `blk_size` = X, and the input bits pass out unchanged as a single block.
- R3: When X > Z, `blk_count` = ceil(X / Z) and `blk_size` = ceil(X / blk_count), which never exceeds Z.
- R4: Z is 504 when `cfg_turbo` = 0 (convolutional coding) and 5114 when `cfg_turbo` = 1 (turbo coding).
- R5: The first C*K - X output bits of the first block are zeros. The remaining output bits are the input bits in arrival order, and exactly C*K beats are produced.
- R6: `out_first` is high on beat 0 of each block, and `out_last` is high on beat K-1 of each block.
- R7: From the cycle after `start` is taken until the sizes are known, `busy` is high and both `in_ready` and `out_valid` are low.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_bit`, `out_first` and `out_last` hold their values.
- R9: `done` is a one-cycle pulse in the cycle after the final beat's handshake.
- R10: A `start` pulse that arrives while a segmentation is in progress is ignored: the sizes and the output stream of the running job are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; taken only when idle |
| cfg_len | input | LEN_W | Total concatenated bit count X |
| cfg_turbo | input | 1 | 1 selects turbo limit, 0 selects convolutional limit |
| in_valid | input | 1 | Input bit present |
| in_bit | input | 1 | Concatenated transport-block bit |
| in_ready | output | 1 | Input bit accepted this cycle when high with in_valid |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Code-block bit (filler or data) |
| out_first | output | 1 | First bit of a code block |
| out_last | output | 1 | Last bit of a code block |
| blk_count | output | LEN_W | Number of code blocks C |
| blk_size | output | LEN_W | Bits per code block K |
| busy | output | 1 | Sizes being computed; input stalled |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The sizes are due only once `busy` has fallen. Each directed task therefore polls `busy` at the falling edge and checks the stall condition on every cycle it spends there, then compares `blk_count` and `blk_size`. Output beats are due in the same cycle as the handshake, because the path from input to output is combinational. The bench sets its inputs at the falling edge, samples one time unit later, and counts beats only where `out_valid` and `out_ready` are both high. `done` must appear exactly one cycle after the counted final beat, and the zero-length pulse one cycle after `start`. Both are checked at those sampling points.

// File: rtl/tbcs_pkg.sv
// Shared types for the code block segmenter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tbcs_pkg;

    // Planner sequence: idle, count blocks, size blocks, stream out.
    typedef enum logic [1:0] {
        PL_IDLE  = 2'd0,
        PL_COUNT = 2'd1,
        PL_SIZE  = 2'd2,
        PL_SEND  = 2'd3
    } plan_state_e;

endpackage

// File: rtl/tbcs_ceil_div.sv
// Rounded-up integer divider, restoring shift-and-subtract.
// Computes ceil(num / den) over W+1 cycles after a go pulse.
// Assumes den != 0 and that num + den - 1 fits in W+1 bits.
module tbcs_ceil_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int NW = W + 1;
    localparam int CW = $clog2(NW + 1);
    localparam int PW = 2 * W + 2;

    logic [NW-1:0] rem, acc, rem_sh, rem_nx, acc_nx;
    logic [W-1:0]  num_q, den_q;
    logic [CW-1:0] cnt;
    logic          run, done_q, ge;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        rem_sh = {rem[NW-2:0], acc[NW-1]};
        ge     = rem_sh >= NW'(den_q);
        rem_nx = ge ? rem_sh - NW'(den_q) : rem_sh;
        acc_nx = {acc[NW-2:0], ge};
    end

    // Iteration control: load on go, step W+1 times, then pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            acc    <= '0;
            num_q  <= '0;
            den_q  <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                num_q <= num;
                den_q <= den;
                rem   <= '0;
                acc   <= NW'(num) + NW'(den) - NW'(1);
                cnt   <= CW'(NW);
                run   <= 1'b1;
            end else if (run) begin
                rem <= rem_nx;
                acc <= acc_nx;
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run    <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = run;
    assign done = done_q;
    assign quo  = acc[W-1:0];

    // R3: the result is the smallest quotient that covers the dividend.
    a_r3_ceil_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (done && num_q != '0) |->
            (PW'(quo) * PW'(den_q) >= PW'(num_q)) &&
            ((PW'(quo) - PW'(1)) * PW'(den_q) < PW'(num_q)));

endmodule

// File: rtl/tbcs_plan.sv
// Segmentation planner: latches the job, derives block count, block size
// and filler count with one shared divider, then hands off to the emitter.
// Assumes the limits fit in LEN_W bits and that start is a single-cycle pulse.
module tbcs_plan
    import tbcs_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int CONV_MAX  = 504,
    parameter int TURBO_MAX = 5114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_turbo,
    input  logic             send_fin,
    output logic             busy,
    output logic             send_go,
    output logic             zero_done,
    output logic [LEN_W-1:0] c_out,
    output logic [LEN_W-1:0] k_out,
    output logic [LEN_W-1:0] fill_out
);
    localparam int PW = 2 * LEN_W;

    plan_state_e      st;
    logic [LEN_W-1:0] len_q, zmax_q, c_q, k_q, fill_q;
    logic [LEN_W-1:0] div_num, div_den, div_quo;
    logic             div_go, div_busy, div_done;

    // Divisor choice: the coding limit first, then the block count.
    always_comb begin
        div_num = len_q;
        div_den = (st == PL_SIZE) ? c_q : zmax_q;
    end

    tbcs_ceil_div #(.W(LEN_W)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quo  (div_quo)
    );

    // Job sequencing through the four planner states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PL_IDLE;
            len_q     <= '0;
            zmax_q    <= '0;
            c_q       <= '0;
            k_q       <= '0;
            fill_q    <= '0;
            div_go    <= 1'b0;
            send_go   <= 1'b0;
            zero_done <= 1'b0;
        end else begin
            div_go    <= 1'b0;
            send_go   <= 1'b0;
            zero_done <= 1'b0;
            unique case (st)
                PL_IDLE: if (start) begin
                    len_q  <= cfg_len;
                    zmax_q <= cfg_turbo ? LEN_W'(TURBO_MAX) : LEN_W'(CONV_MAX);
                    c_q    <= '0;
                    k_q    <= '0;
                    fill_q <= '0;
                    if (cfg_len == '0) begin
                        zero_done <= 1'b1;
                    end else begin
                        st     <= PL_COUNT;
                        div_go <= 1'b1;
                    end
                end
                PL_COUNT: if (div_done) begin
                    c_q    <= div_quo;
                    st     <= PL_SIZE;
                    div_go <= 1'b1;
                end
                PL_SIZE: if (div_done) begin
                    k_q     <= div_quo;
                    fill_q  <= LEN_W'(PW'(c_q) * PW'(div_quo) - PW'(len_q));
                    st      <= PL_SEND;
                    send_go <= 1'b1;
                end
                PL_SEND: if (send_fin) begin
                    st <= PL_IDLE;
                end
                default: st <= PL_IDLE;
            endcase
        end
    end

    assign busy     = (st == PL_COUNT) || (st == PL_SIZE);
    assign c_out    = c_q;
    assign k_out    = k_q;
    assign fill_out = fill_q;

    // R3: a streamed job never uses blocks above the limit or too few bits.
    a_r3_size_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PL_SEND) |->
            (k_q <= zmax_q) && (PW'(k_q) * PW'(c_q) >= PW'(len_q)));

    // R7: the divider only runs while the planner reports busy.
    a_r7_div_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy);

endmodule

// File: rtl/tbcs_emit.sv
// Code block emitter: prepends filler zeros to the first block, forwards the
// concatenated input bits, and marks the first and last bit of each block.
// Assumes k >= 1, c >= 1, fill < k, and upstream holds in_bit until accepted.
module tbcs_emit #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] c_in,
    input  logic [LEN_W-1:0] k_in,
    input  logic [LEN_W-1:0] fill_in,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_first,
    output logic             out_last,
    output logic             fin
);
    logic [LEN_W-1:0] c_q, k_q, pos, blk, fill_left;
    logic             act, filling, fire, at_end;

    // Beat-level combinational view of the current position.
    always_comb begin
        filling   = act && (fill_left != '0);
        out_valid = act && (filling || in_valid);
        out_bit   = filling ? 1'b0 : in_bit;
        in_ready  = act && !filling && out_ready;
        out_first = act && (pos == '0);
        at_end    = pos == (k_q - LEN_W'(1));
        out_last  = act && at_end;
        fire      = out_valid && out_ready;
    end

    // Position, block and filler counters advanced on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act       <= 1'b0;
            c_q       <= '0;
            k_q       <= '0;
            pos       <= '0;
            blk       <= '0;
            fill_left <= '0;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                act       <= 1'b1;
                c_q       <= c_in;
                k_q       <= k_in;
                pos       <= '0;
                blk       <= '0;
                fill_left <= fill_in;
            end else if (fire) begin
                if (filling) begin
                    fill_left <= fill_left - LEN_W'(1);
                end
                if (at_end) begin
                    pos <= '0;
                    blk <= blk + LEN_W'(1);
                    if (blk == c_q - LEN_W'(1)) begin
                        act <= 1'b0;
                        fin <= 1'b1;
                    end
                end else begin
                    pos <= pos + LEN_W'(1);
                end
            end
        end
    end

    // R5: filler bits only ever appear inside the first block.
    a_r5_fill_in_first: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> (blk == '0));

    // R6: a block whose first beat is also its last must be one bit long.
    a_r6_single_bit_block: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_first && out_last) |-> (k_q == LEN_W'(1)));

    // R8: a stalled beat keeps its value and markers.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bit) && $stable(out_first) && $stable(out_last)));

    // R9: the end pulse lasts a single cycle.
    a_r9_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/tbcs_seg.sv
// Code block segmenter top: connects the planner and the emitter.
// Assumes one job at a time; start is honoured only while idle.
module tbcs_seg #(
    parameter int LEN_W     = 16,
    parameter int CONV_MAX  = 504,
    parameter int TURBO_MAX = 5114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_turbo,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_first,
    output logic             out_last,
    output logic [LEN_W-1:0] blk_count,
    output logic [LEN_W-1:0] blk_size,
    output logic             busy,
    output logic             done
);
    logic             send_go, send_fin, zero_done;
    logic [LEN_W-1:0] fill_cnt;

    tbcs_plan #(
        .LEN_W    (LEN_W),
        .CONV_MAX (CONV_MAX),
        .TURBO_MAX(TURBO_MAX)
    ) i_plan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_len  (cfg_len),
        .cfg_turbo(cfg_turbo),
        .send_fin (send_fin),
        .busy     (busy),
        .send_go  (send_go),
        .zero_done(zero_done),
        .c_out    (blk_count),
        .k_out    (blk_size),
        .fill_out (fill_cnt)
    );

    tbcs_emit #(.LEN_W(LEN_W)) i_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (send_go),
        .c_in     (blk_count),
        .k_in     (blk_size),
        .fill_in  (fill_cnt),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_bit  (out_bit),
        .out_first(out_first),
        .out_last (out_last),
        .fin      (send_fin)
    );

    // End-of-job pulse from either the empty path or the last beat.
    assign done = zero_done | send_fin;

    // R7: while sizes are computed, nothing moves on either side.
    a_r7_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!in_ready && !out_valid));

    // R8: back-pressure never lets an input bit slip through.
    a_r8_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);

endmodule

// File: tb/test_tbcs_seg.sv
module test_tbcs_seg;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic             cfg_turbo = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_bit = 1'b0;
    logic             in_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic             out_bit;
    logic             out_first;
    logic             out_last;
    logic [LEN_W-1:0] blk_count;
    logic [LEN_W-1:0] blk_size;
    logic             busy;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tbcs_seg #(.LEN_W(LEN_W)) i_tbcs_seg (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_turbo(cfg_turbo), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_bit(out_bit), .out_first(out_first), .out_last(out_last),
        .blk_count(blk_count), .blk_size(blk_size), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic pat(input int i);
        int h;
        h = i * 40503 + (i >> 2) * 7 + 13;
        return ^h[11:0];
    endfunction

    function automatic logic rdy(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        return ((cyc * 5 + 1) % 7) < 4;
    endfunction

    // Reset state of all outputs.
    task automatic t_reset;
        @(negedge clk);
        chk(!out_valid && !busy && !done && !in_ready, "R7", "idle after reset",
            {out_valid, busy, done, in_ready}, 0);
        chk(blk_count == 0 && blk_size == 0, "R1", "sizes after reset", blk_count, 0);
    endtask

    // R1: zero-length job.
    task automatic t_zero;
        @(negedge clk);
        start = 1'b1; cfg_len = '0; cfg_turbo = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(done == 1'b1, "R1", "done after empty start", done, 1);
        chk(!busy && !out_valid, "R1", "no work on empty job", {busy, out_valid}, 0);
        chk(blk_count == 0 && blk_size == 0, "R1", "empty sizes", blk_count, 0);
        @(negedge clk);
        #1;
        chk(done == 1'b0 && !out_valid, "R1", "done dropped, no beats", done, 0);
    endtask

    // Full job: size check, stream check, end pulse, optional ignored start (R10).
    task automatic t_job(input int len, input bit turbo, input int ec, input int ek,
                         input int mode, input bit inject, input string req);
        int fill, total, idx, beat, e_data, e_mark, e_hold, e_stall, e_busy, polls;
        bit stalled, pv_bit, pv_first, pv_last, last_fired, done_ok, finished;
        fill = ec * ek - len;
        total = ec * ek;
        idx = 0; beat = 0; e_data = 0; e_mark = 0; e_hold = 0; e_stall = 0; e_busy = 0;
        stalled = 0; pv_bit = 0; pv_first = 0; pv_last = 0;
        last_fired = 0; done_ok = 0; finished = 0;
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b0;
        start = 1'b1; cfg_len = LEN_W'(len); cfg_turbo = turbo;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy == 1'b1, "R7", "busy after start", busy, 1);
        polls = 0;
        while (busy && polls < 300) begin
            if (in_ready || out_valid) e_busy++;
            @(negedge clk);
            #1;
            polls++;
        end
        chk(e_busy == 0 && !busy, "R7", "stall while busy", e_busy, 0);
        chk(blk_count == LEN_W'(ec), req, "block count", blk_count, ec);
        chk(blk_size == LEN_W'(ek), req, "block size", blk_size, ek);
        for (int cyc = 0; cyc < 60000 && !finished; cyc++) begin
            @(negedge clk);
            out_ready = rdy(mode, cyc);
            in_valid = (idx < len);
            in_bit = pat(idx);
            start = inject && (beat == ek / 2);
            cfg_len = inject ? LEN_W'(7) : LEN_W'(len);
            #1;
            if (last_fired) begin
                done_ok = done;
                finished = 1;
            end else begin
                if (done) e_mark++;
                if (stalled && (!out_valid || out_bit != pv_bit ||
                    out_first != pv_first || out_last != pv_last)) e_hold++;
                if (!out_ready && in_ready) e_stall++;
                if (out_valid) begin
                    if (out_bit != ((beat < fill) ? 1'b0 : pat(beat - fill))) e_data++;
                    if (out_first != ((beat % ek) == 0)) e_mark++;
                    if (out_last != ((beat % ek) == ek - 1)) e_mark++;
                end
                stalled = out_valid && !out_ready;
                pv_bit = out_bit; pv_first = out_first; pv_last = out_last;
                if (in_valid && in_ready) idx++;
                if (out_valid && out_ready) begin
                    beat++;
                    if (beat == total) last_fired = 1;
                end
            end
        end
        start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        chk(e_data == 0, "R5", "filler and data bits", e_data, 0);
        chk(e_mark == 0, "R6", "block first/last strobes", e_mark, 0);
        chk(beat == total, "R5", "beats produced", beat, total);
        chk(idx == len, "R5", "input bits consumed", idx, len);
        chk(done_ok, "R9", "done after final beat", done_ok, 1);
        if (mode != 0) begin
            chk(e_hold == 0, "R8", "beat held under stall", e_hold, 0);
            chk(e_stall == 0, "R8", "no input taken under stall", e_stall, 0);
        end
        @(negedge clk);
        #1;
        chk(!done && !out_valid, "R9", "done one cycle only", done, 0);
        if (inject) begin
            chk(blk_count == LEN_W'(ec) && blk_size == LEN_W'(ek), "R10",
                "sizes kept after ignored start", blk_size, ek);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_job(100,   1'b0, 1, 100,  0, 1'b0, "R2");
        t_job(504,   1'b0, 1, 504,  1, 1'b0, "R2");
        t_job(505,   1'b0, 2, 253,  0, 1'b0, "R3");
        t_job(1300,  1'b0, 3, 434,  1, 1'b1, "R3");
        t_job(600,   1'b1, 1, 600,  0, 1'b0, "R4");
        t_job(5114,  1'b1, 1, 5114, 0, 1'b0, "R4");
        t_job(5115,  1'b1, 2, 2558, 1, 1'b0, "R4");
        t_job(12000, 1'b1, 3, 4000, 0, 1'b1, "R3");
        t_job(1,     1'b0, 1, 1,    1, 1'b0, "R2");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule